// File: doc/BRIEF.md
# Serial Port Idle-Handshake Controller

This block sits between a power manager and a two-direction serial port. When the power manager requests idle, the block decides whether the port may grant it. The decision depends on several things: which clock drives the port's bit clock, and whether that clock is about to be stopped; the state of the receive and transmit halves; pending DMA, interrupt and buffer-threshold work; and the direction of the frame-sync pins. While idle is granted, the block watches for enabled wake sources and raises a one-cycle wake-up request.

There are two kinds of wake source. The first is a frame-sync pulse on an input pin. It is caught asynchronously by a set-only latch, so the port clock is not needed to see it, and it is then synchronized into the clock domain. The second is a sync-error flag, which is sampled in the clock domain. No wake is raised while the clock in use is about to stop, or while the port is in GPIO mode. Index 0 of every per-direction vector is the receive half and index 1 is the transmit half.

Top module: `spidle_ctrl`

## Requirements
- R1: The clock in use is "about to stop" in two cases: `clk_src`=0 (interface clock) with `hint_ifc_stop`=1, or `clk_src`=1 (external clock) with `hint_fck_stop`=1. In that case acknowledge requires each direction to be quiet, meaning held in reset (`dir_srst`) or disabled (`dir_disable`).
- R2: A direction that is disabled but has `dir_busy`=1 is not quiet until its frame drains. A direction held in reset is quiet whatever its busy flag.
- R3: Any bit of `dma_pend` blocks acknowledge.
- R4: Any bit of `irq_pend` blocks acknowledge, except in GPIO mode (`gpio_mode`=1), where interrupts are not asserted.
- R5: A `thr_pend` bit blocks acknowledge only when the matching `thr_wake_en` bit is 1.
- R6: When the clock in use will not stop, acknowledge needs no disable or reset state.
- R7: Any `fs_out` bit at 1 (frame-sync pin is an output) withholds acknowledge.
- R8: `idle_ack` is registered. It is 0 in reset, follows the grant condition one clock later, and falls on the first clock after `idle_req` falls.
- R9: During granted idle, a frame-sync pulse on an input pin whose `wake_fs_en` bit is 1 gives a one-cycle `wake_req` on the third clock edge after the pulse. The pulse needs no clock edge while it is high.
- R10: During granted idle, a `sync_err` bit whose `wake_serr_en` bit is 1, on an input pin, gives a one-cycle `wake_req` on the next edge. This happens only while `hint_fck_stop`=0.
- R11: While the clock in use is about to stop, no wake-up is generated.
- R12: In GPIO mode no wake-up is generated.
- R13: Frame-sync pulses that arrive when idle is not granted are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Idle request from power manager |
| hint_ifc_stop | input | 1 | Interface clock will be stopped |
| hint_fck_stop | input | 1 | Functional clock will be stopped |
| clk_src | input | 1 | Bit-clock source: 0 interface, 1 external |
| dir_disable | input | 2 | Direction disabled |
| dir_srst | input | 2 | Direction held in software reset |
| dir_busy | input | 2 | Frame in progress |
| dma_pend | input | 2 | DMA request pending |
| irq_pend | input | 2 | Interrupt request pending |
| thr_pend | input | 2 | Buffer-threshold sync pending |
| thr_wake_en | input | 2 | Wake on threshold enabled |
| fs_out | input | 2 | Frame-sync pin is an output |
| fs_pulse | input | 2 | Asynchronous frame-sync pin level |
| sync_err | input | 2 | Frame-sync error flag |
| wake_fs_en | input | 2 | Frame-sync wake enable |
| wake_serr_en | input | 2 | Sync-error wake enable |
| gpio_mode | input | 1 | Port pins used as GPIO |
| idle_ack | output | 1 | Idle acknowledge |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The bench separates the two clock-gating cases and shows that only the clock actually selected matters. A design that decoded the hint without looking at the source would grant idle with the interface hint while running from the external clock. A draining frame on a disabled direction is checked against the same frame on a direction held in reset: a design that treated both alike would either grant idle mid-frame or hang waiting for a reset half. The frame-sync wake is timed edge by edge through the synchronizer, using a pulse that falls before any clock edge. Every wake source is also tried under GPIO mode, under a stopping clock, with the functional clock stopped, and outside idle, where a leaky gate would show as a stray pulse.

// File: rtl/spidle_pkg.sv
package spidle_pkg;
    localparam int NDIR      = 2;
    localparam int DIR_RX    = 0;
    localparam int DIR_TX    = 1;
    localparam int SYNC_MIN  = 2;

    typedef enum logic {
        SRC_IFC = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic dis;
        logic srst;
        logic busy;
    } dir_state_t;

    // True when the clock the port is using will be stopped
    function automatic logic clk_will_stop(clk_src_e src, logic ifc_stop, logic fck_stop);
        return (src == SRC_IFC) ? ifc_stop : fck_stop;
    endfunction

    // Reset halts a direction at once; a disabled one must drain its frame
    function automatic logic dir_is_quiet(dir_state_t s);
        return s.srst | (s.dis & ~s.busy);
    endfunction
endpackage

// File: rtl/spidle_grant.sv
module spidle_grant
    import spidle_pkg::*;
#(
    parameter int ND = NDIR
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    idle_req,
    input  logic                    stopping,
    input  dir_state_t [ND-1:0]     st,
    input  logic [ND-1:0]           dma_pend,
    input  logic [ND-1:0]           irq_pend,
    input  logic [ND-1:0]           thr_pend,
    input  logic [ND-1:0]           thr_wake_en,
    input  logic [ND-1:0]           fs_out,
    input  logic                    gpio_mode,
    output logic                    idle_ack
);
    logic [ND-1:0] quiet;
    logic          work_clear;
    logic          dirs_ok;
    logic          grant;

    for (genvar d = 0; d < ND; d++) begin : g_quiet
        assign quiet[d] = dir_is_quiet(st[d]);
    end

    always_comb begin
        work_clear = ~(|dma_pend)
                   & (gpio_mode | ~(|irq_pend))
                   & ~(|(thr_pend & thr_wake_en));
        dirs_ok    = ~stopping | (&quiet);
        grant      = idle_req & work_clear & dirs_ok & ~(|fs_out);
    end

    always_ff @(posedge clk) begin
        if (rst) idle_ack <= 1'b0;
        else     idle_ack <= grant;
    end

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !idle_req |=> !idle_ack);
    // R3
    ack_dma_chk: assert property (@(posedge clk) disable iff (rst)
        (|dma_pend) |=> !idle_ack);
    // R7
    ack_fsout_chk: assert property (@(posedge clk) disable iff (rst)
        (|fs_out) |=> !idle_ack);
    // R1
    ack_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (stopping && !(&quiet)) |=> !idle_ack);
endmodule

// File: rtl/spidle_fs_catch.sv
module spidle_fs_catch
    import spidle_pkg::*;
#(
    parameter int STAGES = SYNC_MIN
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic fs_async,
    output logic seen
);
    localparam int SW = (STAGES < SYNC_MIN) ? SYNC_MIN : STAGES;

    logic          set_trig;
    logic          caught;
    logic [SW-1:0] sync_q;

    assign set_trig = fs_async & arm;

    // Set-only capture, works with no clock edge; cleared once idle ends
    always_ff @(posedge clk or posedge set_trig) begin
        if (set_trig)          caught <= 1'b1;
        else if (rst || !arm)  caught <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SW-2:0], caught};
    end

    assign seen = sync_q[SW-1];
endmodule

// File: rtl/spidle_wake.sv
module spidle_wake
    import spidle_pkg::*;
#(
    parameter int ND     = NDIR,
    parameter int STAGES = SYNC_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_idle,
    input  logic          stopping,
    input  logic          fck_stop,
    input  logic          gpio_mode,
    input  logic [ND-1:0] fs_out,
    input  logic [ND-1:0] wake_fs_en,
    input  logic [ND-1:0] wake_serr_en,
    input  logic [ND-1:0] sync_err,
    input  logic [ND-1:0] fs_pulse,
    output logic          wake_req
);
    logic          allow;
    logic [ND-1:0] fs_seen;
    logic [ND-1:0] serr_hit;
    logic          ev_now;
    logic          ev_prev;

    assign allow = in_idle & ~stopping & ~gpio_mode;

    for (genvar d = 0; d < ND; d++) begin : g_src
        logic arm_d;
        assign arm_d       = allow & ~fs_out[d] & wake_fs_en[d];
        assign serr_hit[d] = allow & ~fs_out[d] & ~fck_stop
                           & wake_serr_en[d] & sync_err[d];
        spidle_fs_catch #(.STAGES(STAGES)) u_catch (
            .clk      (clk),
            .rst      (rst),
            .arm      (arm_d),
            .fs_async (fs_pulse[d]),
            .seen     (fs_seen[d])
        );
    end

    assign ev_now = (|fs_seen) | (|serr_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_prev  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            ev_prev  <= ev_now;
            wake_req <= ev_now & ~ev_prev;
        end
    end

    // R9
    wake_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);
    // R10
    wake_serr_chk: assert property (@(posedge clk) disable iff (rst)
        ((|serr_hit) && !ev_prev) |=> wake_req);
endmodule

// File: rtl/spidle_ctrl.sv
module spidle_ctrl
    import spidle_pkg::*;
#(
    parameter int ND     = NDIR,
    parameter int STAGES = SYNC_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle_req,
    input  logic          hint_ifc_stop,
    input  logic          hint_fck_stop,
    input  logic          clk_src,
    input  logic [ND-1:0] dir_disable,
    input  logic [ND-1:0] dir_srst,
    input  logic [ND-1:0] dir_busy,
    input  logic [ND-1:0] dma_pend,
    input  logic [ND-1:0] irq_pend,
    input  logic [ND-1:0] thr_pend,
    input  logic [ND-1:0] thr_wake_en,
    input  logic [ND-1:0] fs_out,
    input  logic [ND-1:0] fs_pulse,
    input  logic [ND-1:0] sync_err,
    input  logic [ND-1:0] wake_fs_en,
    input  logic [ND-1:0] wake_serr_en,
    input  logic          gpio_mode,
    output logic          idle_ack,
    output logic          wake_req
);
    dir_state_t [ND-1:0] st;
    logic                stopping;
    logic                in_idle;

    for (genvar d = 0; d < ND; d++) begin : g_st
        assign st[d] = '{dis: dir_disable[d], srst: dir_srst[d], busy: dir_busy[d]};
    end

    assign stopping = clk_will_stop(clk_src_e'(clk_src), hint_ifc_stop, hint_fck_stop);
    assign in_idle  = idle_req & idle_ack;

    spidle_grant #(.ND(ND)) u_grant (
        .clk         (clk),
        .rst         (rst),
        .idle_req    (idle_req),
        .stopping    (stopping),
        .st          (st),
        .dma_pend    (dma_pend),
        .irq_pend    (irq_pend),
        .thr_pend    (thr_pend),
        .thr_wake_en (thr_wake_en),
        .fs_out      (fs_out),
        .gpio_mode   (gpio_mode),
        .idle_ack    (idle_ack)
    );

    spidle_wake #(.ND(ND), .STAGES(STAGES)) u_wake (
        .clk          (clk),
        .rst          (rst),
        .in_idle      (in_idle),
        .stopping     (stopping),
        .fck_stop     (hint_fck_stop),
        .gpio_mode    (gpio_mode),
        .fs_out       (fs_out),
        .wake_fs_en   (wake_fs_en),
        .wake_serr_en (wake_serr_en),
        .sync_err     (sync_err),
        .fs_pulse     (fs_pulse),
        .wake_req     (wake_req)
    );

    // R12
    gpio_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (gpio_mode && $past(gpio_mode) && $past(gpio_mode, 2) && $past(gpio_mode, 3)
         && $past(rst, 3) == 1'b0) |-> !wake_req);
endmodule

// File: tb/spidle_ctrl_test.sv
module spidle_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic idle_req = 1'b0, hint_ifc_stop = 1'b0, hint_fck_stop = 1'b0, clk_src = 1'b0;
    logic [1:0] dir_disable = '0, dir_srst = '0, dir_busy = '0;
    logic [1:0] dma_pend = '0, irq_pend = '0, thr_pend = '0, thr_wake_en = '0;
    logic [1:0] fs_out = '0, fs_pulse = '0, sync_err = '0, wake_fs_en = '0, wake_serr_en = '0;
    logic gpio_mode = 1'b0;
    logic idle_ack, wake_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spidle_ctrl uut (
        .clk(clk), .rst(rst), .idle_req(idle_req),
        .hint_ifc_stop(hint_ifc_stop), .hint_fck_stop(hint_fck_stop), .clk_src(clk_src),
        .dir_disable(dir_disable), .dir_srst(dir_srst), .dir_busy(dir_busy),
        .dma_pend(dma_pend), .irq_pend(irq_pend), .thr_pend(thr_pend),
        .thr_wake_en(thr_wake_en), .fs_out(fs_out), .fs_pulse(fs_pulse),
        .sync_err(sync_err), .wake_fs_en(wake_fs_en), .wake_serr_en(wake_serr_en),
        .gpio_mode(gpio_mode), .idle_ack(idle_ack), .wake_req(wake_req)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic restart;
        idle_req = 0; hint_ifc_stop = 0; hint_fck_stop = 0; clk_src = 0;
        dir_disable = 0; dir_srst = 0; dir_busy = 0; dma_pend = 0; irq_pend = 0;
        thr_pend = 0; thr_wake_en = 0; fs_out = 0; fs_pulse = 0; sync_err = 0;
        wake_fs_en = 0; wake_serr_en = 0; gpio_mode = 0;
        rst = 1; tick; tick; rst = 0;
    endtask

    task automatic pulse_fs(input int d);
        fs_pulse[d] = 1'b1;
        #2;
        fs_pulse[d] = 1'b0;
    endtask

    task automatic count_wake(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            tick;
            if (wake_req) c++;
        end
    endtask

    task automatic t_reset;
        rst = 1; idle_req = 1;
        tick; tick;
        chk(idle_ack, 1'b0, "R8 ack low in reset");
        chk(wake_req, 1'b0, "R8 wake low in reset");
        restart;
    endtask

    task automatic t_ungated;
        restart;
        idle_req = 1;
        #2 chk(idle_ack, 1'b0, "R8 ack not before edge");
        tick;
        chk(idle_ack, 1'b1, "R6 ack with both directions active");
        idle_req = 0;
        tick;
        chk(idle_ack, 1'b0, "R8 ack drops after request falls");
    endtask

    task automatic t_work;
        restart;
        idle_req = 1; dma_pend = 2'b10;
        tick; chk(idle_ack, 1'b0, "R3 dma blocks");
        dma_pend = 0; tick; chk(idle_ack, 1'b1, "R3 ack after dma clears");
        irq_pend = 2'b01; tick; chk(idle_ack, 1'b0, "R4 irq blocks");
        gpio_mode = 1; tick; chk(idle_ack, 1'b1, "R4 irq ignored in gpio mode");
        gpio_mode = 0; irq_pend = 0;
        thr_pend = 2'b01; thr_wake_en = 2'b10;
        tick; chk(idle_ack, 1'b1, "R5 threshold ignored when its wake off");
        thr_wake_en = 2'b01; tick; chk(idle_ack, 1'b0, "R5 threshold blocks when wake on");
        thr_pend = 0; fs_out = 2'b01;
        tick; chk(idle_ack, 1'b0, "R7 output frame-sync blocks");
    endtask

    task automatic t_gated;
        restart;
        idle_req = 1; clk_src = 0; hint_ifc_stop = 1;
        tick; chk(idle_ack, 1'b0, "R1 interface clock stops, dirs active");
        hint_ifc_stop = 0; hint_fck_stop = 1;
        tick; chk(idle_ack, 1'b1, "R1 functional hint irrelevant on interface source");
        clk_src = 1;
        tick; chk(idle_ack, 1'b0, "R1 external source, functional clock stops");
        dir_srst = 2'b11;
        tick; chk(idle_ack, 1'b1, "R1 both in reset grants");
        dir_srst = 2'b10; dir_disable = 2'b01; dir_busy = 2'b01;
        tick; chk(idle_ack, 1'b0, "R2 disabled rx still busy blocks");
        dir_busy = 2'b10;
        tick; chk(idle_ack, 1'b1, "R2 reset tx busy does not block");
    endtask

    task automatic t_fs_wake;
        restart;
        idle_req = 1; wake_fs_en = 2'b01;
        tick; chk(idle_ack, 1'b1, "R9 idle granted");
        pulse_fs(0);
        tick; chk(wake_req, 1'b0, "R9 no wake at edge 1");
        tick; chk(wake_req, 1'b0, "R9 no wake at edge 2");
        tick; chk(wake_req, 1'b1, "R9 wake at edge 3");
        tick; chk(wake_req, 1'b0, "R9 wake lasts one cycle");
    endtask

    task automatic t_fs_outside;
        int c;
        restart;
        wake_fs_en = 2'b11;
        pulse_fs(1);
        count_wake(6, c);
        chk_int(c, 0, "R13 pulse outside idle ignored");
    endtask

    task automatic t_serr;
        int c;
        restart;
        idle_req = 1; wake_serr_en = 2'b10;
        tick;
        sync_err = 2'b10;
        tick; chk(wake_req, 1'b1, "R10 sync-error wake next edge");
        sync_err = 0;
        tick; chk(wake_req, 1'b0, "R10 sync-error wake one cycle");
        hint_fck_stop = 1;
        tick; chk(idle_ack, 1'b1, "R10 idle held on interface source");
        sync_err = 2'b10;
        count_wake(1, c);
        sync_err = 0;
        chk_int(c, 0, "R10 no sync-error wake with functional clock stopped");
    endtask

    task automatic t_gated_wake;
        int c;
        restart;
        idle_req = 1; hint_ifc_stop = 1; dir_srst = 2'b11;
        wake_fs_en = 2'b11; wake_serr_en = 2'b11;
        tick; chk(idle_ack, 1'b1, "R11 gated idle granted");
        pulse_fs(0);
        sync_err = 2'b01;
        count_wake(6, c);
        sync_err = 0;
        chk_int(c, 0, "R11 no wake while clock stops");
    endtask

    task automatic t_gpio_wake;
        int c;
        restart;
        gpio_mode = 1; idle_req = 1; wake_fs_en = 2'b11; wake_serr_en = 2'b11;
        tick; chk(idle_ack, 1'b1, "R12 idle granted in gpio mode");
        pulse_fs(1);
        sync_err = 2'b11;
        count_wake(6, c);
        sync_err = 0;
        chk_int(c, 0, "R12 no wake in gpio mode");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset;
        t_ungated;
        t_work;
        t_gated;
        t_fs_wake;
        t_fs_outside;
        t_serr;
        t_gated_wake;
        t_gpio_wake;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule